// File: doc/BRIEF.md
# Tape Controller Command Sequencer

This block sits between an I/O channel and a set of magnetic tape drives. The channel offers a select: a command code and a unit field. The sequencer validates the select and answers with a one-cycle response code. When it accepts the select, it takes ownership of the controller and arms a down-counter that belongs to the addressed drive. Each time a drive's counter runs out, the sequencer services that drive's current phase. Servicing means a phase strobe naming the drive and the phase, any status flags, and the next phase with its own delay. When no next phase follows, the sequencer releases the controller.

The five delays are held in writable registers: start, stop, per-word, end-of-file mark and short. Outside logic handles the data characters and the medium itself. That logic follows the phase strobes, and it reports medium conditions back on a small status input that is sampled at the moment of service. Rewind and unload hand the channel back after their first phase, so the drive keeps working alone while the controller takes new selects for other drives.

Top module: `tape_cmd_seq`

## Requirements
- R1: After reset the controller is free, no drive counter runs, every output strobe and flag is low, and every drive reads high density (`unit_density` bit = 1). The delay registers return to their defaults (start 29000, stop 10000, word 50, mark 25000, short 2). A reset during an operation abandons it.
- R2: Every cycle with `sel_valid` high is answered in the next cycle with `resp_valid` high and a `resp_code`. The codes are 0 accepted, 1 stall, 2 no such drive, 3 no medium, 4 write protected, 5 bad command. The command codes are 1 read, 2 write, 3 backspace record, 4 backspace file, 5 write end-of-file mark, 6 rewind, 7 unload, 8 set density. Any other code gets 5.
- R3: Only bits 3:0 of the unit field address a drive, and drive d maps to bit d-1 of the per-drive vectors. Drive 0 and any drive above NUM_DRIVES get code 2.
- R4: A select for a valid drive gets code 1 while the controller is owned, or while that drive's counter is running or waiting for service.
- R5: All commands except set density need the drive's `unit_attached` bit and get code 3 without it. Set density is accepted without medium.
- R6: Write and write-mark get code 4 on a drive whose `unit_wprot` bit is set. Read and backspace are accepted on such a drive.
- R7: A delay of value v yields a phase strobe v+1 cycles after it is armed. Read, write and both backspaces arm the start delay. Write-mark arms the mark delay. Rewind, unload and set density arm the short delay.
- R8: Read phases are start (code 1), word (code 2) and stop (code 3). Each word is a strobe spaced by the word delay. A word serviced with `rec_last` high moves to stop after the stop delay. At stop, a connected channel restarts the read after the short delay; otherwise the controller is released.
- R9: Write phases are start (code 4), word (code 5) and stop (code 6). A word phase ends the record when `rec_last` is high or the channel has disconnected. At stop, a connected channel restarts the write after the short delay; otherwise the controller is released.
- R10: Rewind (code 10) and unload (code 12) release the controller and pulse `chan_end` at their first strobe. A second strobe follows one start delay later, with code 11 for rewind and code 13 for unload.
- R11: Set density (strobe code 14) sets the drive's density bit to bit 4 of the saved unit field: 1 is high, 0 is low. It then releases the controller and pulses `chan_end`.
- R12: At a read start, `med_status` 1 (tape mark) or 2 (end of medium) pulses `eof_flag` and releases the controller. Status 3 (record error) pulses `trc_flag`, and the read goes on. Status 4 (load point) pulses `bot_flag`.
- R13: Backspace record (code 7) and backspace file (code 8) treat a tape mark as normal completion, with no `eof_flag`. They then release the controller and pulse `chan_end`. End of medium still gives `eof_flag`.
- R14: A write through `cfg_we` loads delay register `cfg_sel`, where 0 is start, 1 stop, 2 word, 3 mark and 4 short. A write of zero leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_valid | input | 1 | Select offered this cycle |
| sel_cmd | input | 4 | Command code |
| sel_unit | input | UNIT_W | Unit field: bits 3:0 select the drive, bit 4 is the mode |
| resp_valid | output | 1 | Response to last cycle's select |
| resp_code | output | 3 | Response code |
| cfg_we | input | 1 | Delay register write |
| cfg_sel | input | 3 | Delay register index |
| cfg_data | input | DELAY_W | Delay value |
| unit_attached | input | NUM_DRIVES | Medium present per drive |
| unit_wprot | input | NUM_DRIVES | Write protection per drive |
| chan_connected | input | 1 | Channel still connected |
| rec_last | input | 1 | Last word of record (read) or end of record (write) |
| med_status | input | 3 | Medium condition sampled at service |
| ctl_busy | output | 1 | Controller owned |
| busy_unit | output | UNIT_W | Unit field saved by the last accepted select |
| unit_busy | output | NUM_DRIVES | Drive counter running or pending |
| unit_density | output | NUM_DRIVES | 1 high density, 0 low |
| phase_stb | output | 1 | A phase was serviced |
| phase_code | output | 4 | Phase serviced |
| phase_unit | output | 4 | Drive serviced |
| chan_end | output | 1 | Channel end for a non-data command |
| eof_flag | output | 1 | End-of-file condition |
| trc_flag | output | 1 | Transfer check condition |
| bot_flag | output | 1 | Load point reached |

## Verification
A wrong phase register shows at the ports at the next expiry of that drive: the strobe carries the wrong code, or it comes after the wrong delay, one delay period after the fault at most. A stale owner flag shows on the very next select, which is then stalled or wrongly accepted. A density or delay register that is corrupt stays hidden until a later set-density strobe or an operation timed from that register. For this reason the tests measure the cycle distance between strobes, and they read the density bits right after the strobe that writes them.

// File: rtl/tseq_pkg.sv
`timescale 1ns/1ps
// Shared codes for the tape command sequencer.
// Assumes: 4-bit command codes, 4-bit phase codes, 3-bit responses.
package tseq_pkg;
    localparam logic [3:0] CMD_READ      = 4'd1;
    localparam logic [3:0] CMD_WRITE     = 4'd2;
    localparam logic [3:0] CMD_BACK_REC  = 4'd3;
    localparam logic [3:0] CMD_BACK_FILE = 4'd4;
    localparam logic [3:0] CMD_MARK      = 4'd5;
    localparam logic [3:0] CMD_REWIND    = 4'd6;
    localparam logic [3:0] CMD_UNLOAD    = 4'd7;
    localparam logic [3:0] CMD_DENSITY   = 4'd8;

    localparam logic [3:0] PH_IDLE      = 4'd0;
    localparam logic [3:0] PH_RD_START  = 4'd1;
    localparam logic [3:0] PH_RD_WORD   = 4'd2;
    localparam logic [3:0] PH_RD_STOP   = 4'd3;
    localparam logic [3:0] PH_WR_START  = 4'd4;
    localparam logic [3:0] PH_WR_WORD   = 4'd5;
    localparam logic [3:0] PH_WR_STOP   = 4'd6;
    localparam logic [3:0] PH_BACK_REC  = 4'd7;
    localparam logic [3:0] PH_BACK_FILE = 4'd8;
    localparam logic [3:0] PH_MARK      = 4'd9;
    localparam logic [3:0] PH_REW_A     = 4'd10;
    localparam logic [3:0] PH_REW_B     = 4'd11;
    localparam logic [3:0] PH_UNL_A     = 4'd12;
    localparam logic [3:0] PH_UNL_B     = 4'd13;
    localparam logic [3:0] PH_DENS      = 4'd14;

    localparam logic [2:0] RESP_OK     = 3'd0;
    localparam logic [2:0] RESP_STALL  = 3'd1;
    localparam logic [2:0] RESP_NODEV  = 3'd2;
    localparam logic [2:0] RESP_NOMED  = 3'd3;
    localparam logic [2:0] RESP_WPROT  = 3'd4;
    localparam logic [2:0] RESP_BADCMD = 3'd5;

    localparam int         NUM_DLY   = 5;
    localparam logic [2:0] DLY_START = 3'd0;
    localparam logic [2:0] DLY_STOP  = 3'd1;
    localparam logic [2:0] DLY_WORD  = 3'd2;
    localparam logic [2:0] DLY_MARK  = 3'd3;
    localparam logic [2:0] DLY_SHORT = 3'd4;

    localparam logic [2:0] MS_OK     = 3'd0;
    localparam logic [2:0] MS_TMARK  = 3'd1;
    localparam logic [2:0] MS_EOM    = 3'd2;
    localparam logic [2:0] MS_RECERR = 3'd3;
    localparam logic [2:0] MS_LOADPT = 3'd4;

    // Command is one of the eight defined codes
    function automatic logic cmd_known(input logic [3:0] c);
        return (c >= CMD_READ) && (c <= CMD_DENSITY);
    endfunction

    // Per-command table: medium must be present
    function automatic logic cmd_needs_medium(input logic [3:0] c);
        case (c)
            CMD_READ, CMD_WRITE, CMD_BACK_REC, CMD_BACK_FILE,
            CMD_MARK, CMD_REWIND, CMD_UNLOAD: return 1'b1;
            default:                          return 1'b0;
        endcase
    endfunction

    // Per-command table: command alters the medium
    function automatic logic cmd_writes(input logic [3:0] c);
        return (c == CMD_WRITE) || (c == CMD_MARK);
    endfunction

    // First phase entered on acceptance
    function automatic logic [3:0] cmd_first_phase(input logic [3:0] c);
        case (c)
            CMD_READ:      return PH_RD_START;
            CMD_WRITE:     return PH_WR_START;
            CMD_BACK_REC:  return PH_BACK_REC;
            CMD_BACK_FILE: return PH_BACK_FILE;
            CMD_MARK:      return PH_MARK;
            CMD_REWIND:    return PH_REW_A;
            CMD_UNLOAD:    return PH_UNL_A;
            CMD_DENSITY:   return PH_DENS;
            default:       return PH_IDLE;
        endcase
    endfunction

    // Delay register armed on acceptance
    function automatic logic [2:0] cmd_first_delay(input logic [3:0] c);
        case (c)
            CMD_MARK:                            return DLY_MARK;
            CMD_REWIND, CMD_UNLOAD, CMD_DENSITY: return DLY_SHORT;
            default:                             return DLY_START;
        endcase
    endfunction
endpackage

// File: rtl/tseq_delay_bank.sv
`timescale 1ns/1ps
// Holds the five programmable phase delays.
// Assumes: defaults are nonzero; a zero write is dropped so no delay becomes zero.
module tseq_delay_bank
    import tseq_pkg::*;
#(
    parameter int DELAY_W   = 24,
    parameter int DEF_START = 29000,
    parameter int DEF_STOP  = 10000,
    parameter int DEF_WORD  = 50,
    parameter int DEF_MARK  = 25000,
    parameter int DEF_SHORT = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [2:0]                        cfg_sel,
    input  logic [DELAY_W-1:0]                cfg_data,
    output logic [NUM_DLY-1:0][DELAY_W-1:0]   dly
);
    localparam logic [NUM_DLY-1:0][DELAY_W-1:0] DEFAULTS = {
        DELAY_W'(DEF_SHORT), DELAY_W'(DEF_MARK), DELAY_W'(DEF_WORD),
        DELAY_W'(DEF_STOP),  DELAY_W'(DEF_START)};

    for (genvar g = 0; g < NUM_DLY; g++) begin : g_reg
        // One delay register: reload default on reset, accept nonzero writes
        always_ff @(posedge clk) begin
            if (!rst_n)
                dly[g] <= DEFAULTS[g];
            else if (cfg_we && (cfg_sel == 3'(g)) && (cfg_data != '0))
                dly[g] <= cfg_data;
        end
    end
endmodule

// File: rtl/tseq_unit_timer.sv
`timescale 1ns/1ps
// Per-drive down-counter. A load of v raises done v cycles later;
// done stays high until acknowledged or reloaded.
// Assumes: load value is never zero.
module tseq_unit_timer #(
    parameter int DELAY_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DELAY_W-1:0] load_val,
    input  logic               ack,
    output logic               busy,
    output logic               done
);
    logic [DELAY_W-1:0] count;

    // Count down, latch expiry until serviced
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            done  <= 1'b0;
        end else if (load) begin
            count <= load_val;
            done  <= 1'b0;
        end else begin
            if (ack) done <= 1'b0;
            if (count != '0) begin
                count <= count - 1'b1;
                if (count == DELAY_W'(1)) done <= 1'b1;
            end
        end
    end

    // Drive is unavailable while counting or waiting for service
    always_comb busy = (count != '0) || done;
endmodule

// File: rtl/tseq_select.sv
`timescale 1ns/1ps
// Combinational check of a select against drive and controller state.
// Assumes: NUM_DRIVES <= 15; unit field bits 3:0 carry the drive number.
module tseq_select
    import tseq_pkg::*;
#(
    parameter int NUM_DRIVES = 8,
    parameter int UNIT_W     = 6,
    parameter int IDX_W      = 3
) (
    input  logic [3:0]            cmd,
    input  logic [UNIT_W-1:0]     unit_field,
    input  logic                  ctl_busy,
    input  logic [NUM_DRIVES-1:0] unit_busy,
    input  logic [NUM_DRIVES-1:0] unit_attached,
    input  logic [NUM_DRIVES-1:0] unit_wprot,
    output logic [2:0]            resp,
    output logic [IDX_W-1:0]      idx
);
    logic [3:0] drive;
    logic       drv_ok;

    // Priority of refusals: command, drive, stall, medium, protection
    always_comb begin
        drive  = unit_field[3:0];
        drv_ok = (drive != 4'd0) && (int'(drive) <= NUM_DRIVES);
        idx    = IDX_W'(drive - 4'd1);
        if (!cmd_known(cmd))
            resp = RESP_BADCMD;
        else if (!drv_ok)
            resp = RESP_NODEV;
        else if (ctl_busy || unit_busy[idx])
            resp = RESP_STALL;
        else if (cmd_needs_medium(cmd) && !unit_attached[idx])
            resp = RESP_NOMED;
        else if (cmd_writes(cmd) && unit_wprot[idx])
            resp = RESP_WPROT;
        else
            resp = RESP_OK;
    end
endmodule

// File: rtl/tape_cmd_seq.sv
`timescale 1ns/1ps
// Tape controller command sequencer: accepts selects, arms per-drive
// delays, services expired drives one per cycle (lowest drive first),
// and reports phase strobes and medium flags.
// Assumes: UNIT_W >= 5 (bit 4 is the mode bit); medium status is valid
// in the cycle a drive is serviced.
module tape_cmd_seq
    import tseq_pkg::*;
#(
    parameter int NUM_DRIVES = 8,
    parameter int DELAY_W    = 24,
    parameter int UNIT_W     = 6,
    parameter int DEF_START  = 29000,
    parameter int DEF_STOP   = 10000,
    parameter int DEF_WORD   = 50,
    parameter int DEF_MARK   = 25000,
    parameter int DEF_SHORT  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel_valid,
    input  logic [3:0]            sel_cmd,
    input  logic [UNIT_W-1:0]     sel_unit,
    output logic                  resp_valid,
    output logic [2:0]            resp_code,
    input  logic                  cfg_we,
    input  logic [2:0]            cfg_sel,
    input  logic [DELAY_W-1:0]    cfg_data,
    input  logic [NUM_DRIVES-1:0] unit_attached,
    input  logic [NUM_DRIVES-1:0] unit_wprot,
    input  logic                  chan_connected,
    input  logic                  rec_last,
    input  logic [2:0]            med_status,
    output logic                  ctl_busy,
    output logic [UNIT_W-1:0]     busy_unit,
    output logic [NUM_DRIVES-1:0] unit_busy,
    output logic [NUM_DRIVES-1:0] unit_density,
    output logic                  phase_stb,
    output logic [3:0]            phase_code,
    output logic [3:0]            phase_unit,
    output logic                  chan_end,
    output logic                  eof_flag,
    output logic                  trc_flag,
    output logic                  bot_flag
);
    localparam int IDX_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;

    logic [NUM_DLY-1:0][DELAY_W-1:0]    dly;
    logic [NUM_DRIVES-1:0][3:0]         phase_q;
    logic [NUM_DRIVES-1:0]              tmr_done, tmr_load, tmr_ack;
    logic [NUM_DRIVES-1:0][DELAY_W-1:0] tmr_val;
    logic [2:0]                         sel_resp;
    logic [IDX_W-1:0]                   sel_idx, svc_idx;
    logic                               accept, svc_hit;
    logic [3:0]                         svc_phase, nxt_phase;
    logic [2:0]                         nxt_dly;
    logic                               nxt_load, clr_busy, f_end, f_eof, f_trc, f_bot, set_dens;
    logic                               st_eof;

    tseq_delay_bank #(
        .DELAY_W(DELAY_W), .DEF_START(DEF_START), .DEF_STOP(DEF_STOP),
        .DEF_WORD(DEF_WORD), .DEF_MARK(DEF_MARK), .DEF_SHORT(DEF_SHORT)
    ) u_dly (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .dly(dly)
    );

    tseq_select #(.NUM_DRIVES(NUM_DRIVES), .UNIT_W(UNIT_W), .IDX_W(IDX_W)) u_sel (
        .cmd(sel_cmd), .unit_field(sel_unit), .ctl_busy(ctl_busy),
        .unit_busy(unit_busy), .unit_attached(unit_attached),
        .unit_wprot(unit_wprot), .resp(sel_resp), .idx(sel_idx)
    );

    // Select is accepted only with an OK verdict
    always_comb accept = sel_valid && (sel_resp == RESP_OK);

    // Pick the lowest-numbered expired drive for service
    always_comb begin
        svc_hit = 1'b0;
        svc_idx = '0;
        for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
            if (tmr_done[i]) begin
                svc_hit = 1'b1;
                svc_idx = IDX_W'(i);
            end
        end
        svc_phase = phase_q[svc_idx];
    end

    // Decide the next phase and the side effects of servicing one drive
    always_comb begin
        st_eof    = (med_status == MS_TMARK) || (med_status == MS_EOM);
        nxt_phase = PH_IDLE;
        nxt_dly   = DLY_SHORT;
        nxt_load  = 1'b0;
        clr_busy  = 1'b0;
        f_end     = 1'b0;
        f_eof     = 1'b0;
        f_trc     = 1'b0;
        f_bot     = 1'b0;
        set_dens  = 1'b0;
        case (svc_phase)
            PH_RD_START: begin
                if (st_eof) begin
                    f_eof    = 1'b1;
                    clr_busy = 1'b1;
                end else begin
                    f_trc = (med_status == MS_RECERR);
                    f_bot = (med_status == MS_LOADPT);
                    if (!chan_connected) clr_busy = 1'b1;
                    else begin
                        nxt_phase = PH_RD_WORD; nxt_dly = DLY_WORD; nxt_load = 1'b1;
                    end
                end
            end
            PH_RD_WORD: begin
                nxt_load = 1'b1;
                if (rec_last) begin nxt_phase = PH_RD_STOP; nxt_dly = DLY_STOP; end
                else          begin nxt_phase = PH_RD_WORD; nxt_dly = DLY_WORD; end
            end
            PH_RD_STOP, PH_WR_STOP: begin
                if (chan_connected) begin
                    nxt_phase = (svc_phase == PH_RD_STOP) ? PH_RD_START : PH_WR_START;
                    nxt_dly   = DLY_SHORT;
                    nxt_load  = 1'b1;
                end else clr_busy = 1'b1;
            end
            PH_WR_START: begin
                if (!chan_connected) clr_busy = 1'b1;
                else begin
                    nxt_phase = PH_WR_WORD; nxt_dly = DLY_WORD; nxt_load = 1'b1;
                end
            end
            PH_WR_WORD: begin
                nxt_load = 1'b1;
                if (!chan_connected || rec_last) begin nxt_phase = PH_WR_STOP; nxt_dly = DLY_STOP; end
                else                             begin nxt_phase = PH_WR_WORD; nxt_dly = DLY_WORD; end
            end
            PH_BACK_REC, PH_BACK_FILE, PH_MARK: begin
                f_eof    = (svc_phase == PH_MARK) ? st_eof : (med_status == MS_EOM);
                f_trc    = (med_status == MS_RECERR);
                f_bot    = (med_status == MS_LOADPT);
                clr_busy = 1'b1;
                f_end    = 1'b1;
            end
            PH_REW_A, PH_UNL_A: begin
                nxt_phase = (svc_phase == PH_REW_A) ? PH_REW_B : PH_UNL_B;
                nxt_dly   = DLY_START;
                nxt_load  = 1'b1;
                clr_busy  = 1'b1;
                f_end     = 1'b1;
            end
            PH_DENS: begin
                set_dens = 1'b1;
                clr_busy = 1'b1;
                f_end    = 1'b1;
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_unit
        logic by_sel, by_svc;
        // Route arm requests from acceptance or service to this drive
        always_comb begin
            by_sel      = accept && (sel_idx == IDX_W'(g));
            by_svc      = svc_hit && (svc_idx == IDX_W'(g));
            tmr_load[g] = by_sel || (by_svc && nxt_load);
            tmr_ack[g]  = by_svc;
            tmr_val[g]  = by_sel ? dly[cmd_first_delay(sel_cmd)] : dly[nxt_dly];
        end

        tseq_unit_timer #(.DELAY_W(DELAY_W)) u_tmr (
            .clk(clk), .rst_n(rst_n), .load(tmr_load[g]), .load_val(tmr_val[g]),
            .ack(tmr_ack[g]), .busy(unit_busy[g]), .done(tmr_done[g])
        );
    end

    // Phase registers, controller ownership and density bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= '0;
            ctl_busy     <= 1'b0;
            busy_unit    <= '0;
            unit_density <= '1;
        end else begin
            if (accept) begin
                phase_q[sel_idx] <= cmd_first_phase(sel_cmd);
                ctl_busy         <= 1'b1;
                busy_unit        <= sel_unit;
            end else if (svc_hit && clr_busy) begin
                ctl_busy <= 1'b0;
            end
            if (svc_hit) phase_q[svc_idx] <= nxt_phase;
            if (svc_hit && set_dens) unit_density[svc_idx] <= busy_unit[4];
        end
    end

    // Registered response and phase reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RESP_OK;
            phase_stb  <= 1'b0;
            phase_code <= PH_IDLE;
            phase_unit <= 4'd0;
            chan_end   <= 1'b0;
            eof_flag   <= 1'b0;
            trc_flag   <= 1'b0;
            bot_flag   <= 1'b0;
        end else begin
            resp_valid <= sel_valid;
            resp_code  <= sel_resp;
            phase_stb  <= svc_hit;
            phase_code <= svc_phase;
            phase_unit <= 4'(svc_idx) + 4'd1;
            chan_end   <= svc_hit && f_end;
            eof_flag   <= svc_hit && f_eof;
            trc_flag   <= svc_hit && f_trc;
            bot_flag   <= svc_hit && f_bot;
        end
    end
endmodule

// File: rtl/tseq_checker.sv
`timescale 1ns/1ps
// Property checker for the tape command sequencer, bound to the top.
// Assumes: observes ports only.
module tseq_checker
    import tseq_pkg::*;
#(
    parameter int UNIT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_valid,
    input logic              resp_valid,
    input logic [2:0]        resp_code,
    input logic              ctl_busy,
    input logic [UNIT_W-1:0] busy_unit,
    input logic              phase_stb,
    input logic [3:0]        phase_code,
    input logic              chan_end,
    input logic              eof_flag,
    input logic              trc_flag,
    input logic              bot_flag
);
    // R2
    resp_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |=> resp_valid);
    // R4
    stall_while_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(ctl_busy)) |-> (resp_code != RESP_OK));
    // R4
    accept_takes_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == RESP_OK) |-> ctl_busy);
    // R4
    owner_field_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_busy && $past(ctl_busy)) |-> $stable(busy_unit));
    // R12
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({eof_flag, trc_flag, bot_flag}));
    // R10
    chan_end_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_end |-> phase_stb);
    // R10
    rewind_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_stb && (phase_code == PH_REW_A || phase_code == PH_UNL_A)) |-> (!ctl_busy && chan_end));
    // R11
    density_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_stb && phase_code == PH_DENS) |-> (!ctl_busy && chan_end));
endmodule

bind tape_cmd_seq tseq_checker #(.UNIT_W(UNIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .resp_valid(resp_valid),
    .resp_code(resp_code), .ctl_busy(ctl_busy), .busy_unit(busy_unit),
    .phase_stb(phase_stb), .phase_code(phase_code), .chan_end(chan_end),
    .eof_flag(eof_flag), .trc_flag(trc_flag), .bot_flag(bot_flag)
);

// File: tb/tb_tape_cmd_seq.sv
`timescale 1ns/1ps
module tb_tape_cmd_seq;
    localparam int N = 8;

    typedef struct packed {
        logic [3:0] c;
        logic [5:0] u;
        logic [2:0] e;
    } vec_t;

    // attached = 8'h7F (drive 8 absent), wprot = 8'h04 (drive 3)
    localparam vec_t TABLE [12] = '{
        '{4'd0, 6'd1,  3'd5},   // R2 undefined command
        '{4'd9, 6'd1,  3'd5},   // R2 undefined command
        '{4'd1, 6'd0,  3'd2},   // R3 drive 0
        '{4'd1, 6'd9,  3'd2},   // R3 drive above count
        '{4'd1, 6'h21, 3'd0},   // R3 high bits ignored -> drive 1
        '{4'd1, 6'd8,  3'd3},   // R5 no medium
        '{4'd8, 6'd8,  3'd0},   // R5 density needs no medium
        '{4'd2, 6'd3,  3'd4},   // R6 write on protected
        '{4'd5, 6'd3,  3'd4},   // R6 mark on protected
        '{4'd1, 6'd3,  3'd0},   // R6 read on protected
        '{4'd3, 6'd3,  3'd0},   // R6 backspace on protected
        '{4'd6, 6'd8,  3'd3}    // R5 rewind without medium
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_valid = 1'b0;
    logic [3:0] sel_cmd = '0;
    logic [5:0] sel_unit = '0;
    logic resp_valid;
    logic [2:0] resp_code;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [23:0] cfg_data = '0;
    logic [N-1:0] unit_attached = 8'h7F;
    logic [N-1:0] unit_wprot = 8'h04;
    logic chan_connected = 1'b0;
    logic rec_last = 1'b1;
    logic [2:0] med_status = '0;
    logic ctl_busy;
    logic [5:0] busy_unit;
    logic [N-1:0] unit_busy, unit_density;
    logic phase_stb;
    logic [3:0] phase_code, phase_unit;
    logic chan_end, eof_flag, trc_flag, bot_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tape_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_cmd(sel_cmd),
        .sel_unit(sel_unit), .resp_valid(resp_valid), .resp_code(resp_code),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .unit_attached(unit_attached), .unit_wprot(unit_wprot),
        .chan_connected(chan_connected), .rec_last(rec_last), .med_status(med_status),
        .ctl_busy(ctl_busy), .busy_unit(busy_unit), .unit_busy(unit_busy),
        .unit_density(unit_density), .phase_stb(phase_stb), .phase_code(phase_code),
        .phase_unit(phase_unit), .chan_end(chan_end), .eof_flag(eof_flag),
        .trc_flag(trc_flag), .bot_flag(bot_flag)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_sel(input logic [3:0] c, input logic [5:0] u, output logic [2:0] r);
        sel_cmd = c; sel_unit = u; sel_valid = 1'b1;
        @(negedge clk);
        sel_valid = 1'b0;
        r = resp_code;
    endtask

    task automatic wait_next(output int k);
        @(negedge clk);
        k = 1;
        while (!phase_stb && k < 40000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic wait_idle();
        int guard = 0;
        while ((ctl_busy || (|unit_busy)) && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic write_cfg(input logic [2:0] s, input logic [23:0] d);
        cfg_sel = s; cfg_data = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] r;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctl_busy", ctl_busy, 0);
        check("R1 unit_busy", unit_busy, 0);
        check("R1 phase_stb", phase_stb, 0);
        check("R1 density", unit_density, 8'hFF);

        // R14 short delays for the rest of the run
        write_cfg(3'd0, 24'd6);
        write_cfg(3'd1, 24'd5);
        write_cfg(3'd2, 24'd3);
        write_cfg(3'd3, 24'd4);
        write_cfg(3'd4, 24'd2);

        // Table of select vectors: R2 R3 R5 R6
        for (int i = 0; i < 12; i++) begin
            do_sel(TABLE[i].c, TABLE[i].u, r);
            check($sformatf("R2 resp_valid entry %0d", i), resp_valid, 1);
            check($sformatf("R2/R3/R5/R6 code entry %0d", i), r, TABLE[i].e);
            wait_idle();
        end

        // R7 R8 read flow
        chan_connected = 1'b1; rec_last = 1'b1; med_status = 3'd0;
        do_sel(4'd1, 6'd2, r);
        check("R2 read accept", r, 0);
        wait_next(k);
        check("R7 start delay", k, 7);
        check("R8 read start code", phase_code, 1);
        check("R8 read unit", phase_unit, 2);
        wait_next(k);
        check("R8 word delay", k, 4);
        check("R8 word code", phase_code, 2);
        wait_next(k);
        check("R8 stop delay", k, 6);
        check("R8 stop code", phase_code, 3);
        wait_next(k);
        check("R8 restart after short", k, 3);
        check("R8 restart code", phase_code, 1);
        wait_next(k);
        chan_connected = 1'b0;
        wait_next(k);
        check("R8 stop code 2", phase_code, 3);
        check("R8 release at stop", ctl_busy, 0);
        wait_idle();

        // R9 write ended by rec_last
        chan_connected = 1'b1; rec_last = 1'b0;
        do_sel(4'd2, 6'd4, r);
        wait_next(k);
        check("R9 write start code", phase_code, 4);
        wait_next(k);
        check("R9 word code", phase_code, 5);
        check("R9 word delay", k, 4);
        rec_last = 1'b1; chan_connected = 1'b0;
        wait_next(k);
        check("R9 last word code", phase_code, 5);
        wait_next(k);
        check("R9 stop delay", k, 6);
        check("R9 stop code", phase_code, 6);
        check("R9 release", ctl_busy, 0);
        wait_idle();

        // R9 write ended by disconnect
        chan_connected = 1'b1; rec_last = 1'b0;
        do_sel(4'd2, 6'd4, r);
        wait_next(k);
        chan_connected = 1'b0;
        wait_next(k);
        wait_next(k);
        check("R9 disconnect ends record", phase_code, 6);
        check("R9 disconnect stop delay", k, 6);
        wait_idle();

        // R4 controller busy stall
        chan_connected = 1'b1; rec_last = 1'b1;
        do_sel(4'd1, 6'd1, r);
        do_sel(4'd8, 6'd2, r);
        check("R4 stall on owned controller", r, 1);
        chan_connected = 1'b0;
        wait_idle();

        // R12 tape mark at read start
        chan_connected = 1'b1; med_status = 3'd1;
        do_sel(4'd1, 6'd5, r);
        wait_next(k);
        check("R12 eof on tape mark", eof_flag, 1);
        check("R12 release on tape mark", ctl_busy, 0);
        wait_idle();
        // R12 record error continues
        med_status = 3'd3;
        do_sel(4'd1, 6'd5, r);
        wait_next(k);
        check("R12 trc flag", trc_flag, 1);
        check("R12 record error keeps owner", ctl_busy, 1);
        chan_connected = 1'b0; med_status = 3'd0;
        wait_idle();

        // R13 backspace over tape mark
        med_status = 3'd1;
        do_sel(4'd3, 6'd5, r);
        wait_next(k);
        check("R13 backspace code", phase_code, 7);
        check("R13 no eof on tape mark", eof_flag, 0);
        check("R13 chan_end", chan_end, 1);
        check("R13 release", ctl_busy, 0);
        wait_idle();
        med_status = 3'd4;
        do_sel(4'd4, 6'd5, r);
        wait_next(k);
        check("R12 bot flag on backspace file", bot_flag, 1);
        wait_idle();
        med_status = 3'd2;
        do_sel(4'd3, 6'd5, r);
        wait_next(k);
        check("R13 eof on end of medium", eof_flag, 1);
        med_status = 3'd0;
        wait_idle();

        // R10 rewind two phases
        do_sel(4'd6, 6'd6, r);
        wait_next(k);
        check("R7 short delay", k, 3);
        check("R10 rewind first code", phase_code, 10);
        check("R10 chan_end", chan_end, 1);
        check("R10 released", ctl_busy, 0);
        check("R4 drive still busy", unit_busy[5], 1);
        do_sel(4'd1, 6'd6, r);
        check("R4 stall on busy drive", r, 1);
        wait_next(k);
        check("R10 rewind second delay", k, 6);
        check("R10 rewind second code", phase_code, 11);
        check("R10 rewind unit", phase_unit, 6);
        wait_idle();

        // R10 unload
        do_sel(4'd7, 6'd7, r);
        wait_next(k);
        check("R10 unload first code", phase_code, 12);
        wait_next(k);
        check("R10 unload second delay", k, 7);
        check("R10 unload second code", phase_code, 13);
        wait_idle();

        // R11 density
        do_sel(4'd8, 6'h02, r);
        wait_next(k);
        check("R11 density code", phase_code, 14);
        check("R11 low density", unit_density[1], 0);
        check("R11 chan_end", chan_end, 1);
        wait_idle();
        do_sel(4'd8, 6'h12, r);
        wait_next(k);
        check("R11 high density", unit_density[1], 1);
        wait_idle();

        // R7 mark delay
        do_sel(4'd5, 6'd1, r);
        wait_next(k);
        check("R7 mark delay", k, 5);
        check("R7 mark code", phase_code, 9);
        wait_idle();

        // R14 zero write ignored, nonzero taken
        write_cfg(3'd4, 24'd0);
        do_sel(4'd8, 6'h13, r);
        wait_next(k);
        check("R14 zero write ignored", k, 3);
        wait_idle();
        write_cfg(3'd4, 24'd9);
        do_sel(4'd8, 6'h13, r);
        wait_next(k);
        check("R14 new short delay", k, 10);
        wait_idle();

        // R1 reset mid operation
        chan_connected = 1'b1;
        do_sel(4'd8, 6'h04, r);
        do_sel(4'd1, 6'd2, r);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset clears owner", ctl_busy, 0);
        check("R1 reset clears counters", unit_busy, 0);
        check("R1 reset density", unit_density, 8'hFF);
        chan_connected = 1'b0;
        do_sel(4'd8, 6'h11, r);
        wait_next(k);
        check("R1 default short delay", k, 3);
        wait_idle();

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule